// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Per-Port Read Latency Select

This block is a true dual-port synchronous memory. It has two ports, A and B. Each port has its own clock, its own synchronous reset and its own input register. That register captures the two select lines, the write strobe, the two lane enables, the output enable, the address and the write data on every rising edge. Either port can read or write any word in the same cycle as the other port.

Each port has a latency strap (`pipe_a`, `pipe_b`) that sets how read data comes out. In flow-through mode the stored word is driven in the cycle right after the capturing edge. In pipelined mode the word passes through one more register and comes out a cycle later. A port drives `rvalid` only for a selected read with output enable set. In every other cycle its data bus reads zero.

When both ports write the same word on the same edge, port A wins on every lane it enables, and `clash` flags the event. Storage is two banks, one per port. Each bank is written by only one clock. A word's value is the XOR of the two banks at that address.

Top module: `dpram_dual_mode`

## Requirements
- R1: Either port can write any word, and a word written through one port can be read back through the other.
- R2: A write captured at rising edge n is stored at edge n+1, so a read captured at edge n+1 returns it. A read captured on the same edge as the other port's write to that address returns the previous contents.
- R3: With the strap low (flow-through), a read captured at edge n drives `rvalid`=1 and the stored word from edge n until edge n+1.
- R4: With the strap high (pipelined), a read captured at edge n drives `rvalid`=1 and the stored word from edge n+1 until edge n+2.
- R5: A port is deselected in a cycle when its `en_lo` input is 1 or its `en_hi` input is 0 at the capturing edge. A deselected cycle writes nothing and produces no valid read.
- R6: In pipelined mode, after a deselected cycle `rvalid` stays 0 for the cycle that follows the first reselected read's capturing edge. Valid data appears one cycle later.
- R7: When both ports write the same address on the same edge, `clash` is 1 from that edge to the next. Lanes that port A enables keep A's data. Lanes that only B enables take B's data.
- R8: Lane enable bit 1 gates bits [DW-1:DW/2] and bit 0 gates bits [DW/2-1:0] of a write. A read always returns the full word.
- R9: When output enable is 0 at the capturing edge, or the cycle is a write, that cycle's read slot shows `rvalid`=0 and `rdata` all zeros.
- R10: Depth is 2^AW words of DW bits (DW even). Address 0 and address 2^AW-1 both hold data independently.
- R11: While reset is high, and after it, until a read is captured, `rvalid` is 0 and `rdata` is zero. `clash` is 0 while reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| pipe_a | input | 1 | Port A latency strap: 1 pipelined, 0 flow-through |
| en_lo_a | input | 1 | Port A select, must be 0 to select |
| en_hi_a | input | 1 | Port A select, must be 1 to select |
| wr_a | input | 1 | Port A write (1) or read (0) |
| lanes_a | input | 2 | Port A lane write enables (bit 1 upper half) |
| oe_a | input | 1 | Port A output enable, captured with the address |
| addr_a | input | AW | Port A word address |
| wdata_a | input | DW | Port A write data |
| rdata_a | output | DW | Port A read data, zero when not valid |
| rvalid_a | output | 1 | Port A read data valid |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| pipe_b | input | 1 | Port B latency strap |
| en_lo_b | input | 1 | Port B select, must be 0 |
| en_hi_b | input | 1 | Port B select, must be 1 |
| wr_b | input | 1 | Port B write (1) or read (0) |
| lanes_b | input | 2 | Port B lane write enables |
| oe_b | input | 1 | Port B output enable |
| addr_b | input | AW | Port B word address |
| wdata_b | input | DW | Port B write data |
| rdata_b | output | DW | Port B read data |
| rvalid_b | output | 1 | Port B read data valid |
| clash | output | 1 | Same-address write by both ports on the last edge |

## Verification
The properties assume that both ports run on one common clock. Collision and `clash` only have a meaning against a shared edge, and the checker samples port B on port A's clock. They also assume that a latency strap stays still for at least two cycles before the outputs it governs are judged. The stimulus ties `clk_b` to the same clock as `clk_a`. It changes a strap only after three cycles with both ports deselected, and no read slots are checked in those cycles.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;

    localparam int LANES = 2;

    typedef enum logic {
        RD_FLOW = 1'b0,
        RD_PIPE = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic             sel;
        logic             wr;
        logic             oe;
        logic [LANES-1:0] lane;
    } port_ctl_t;

    function automatic logic port_selected(input logic en_lo, input logic en_hi);
        return !en_lo && en_hi;
    endfunction

    // lanes a losing writer may still commit when the other port wins the word
    function automatic logic [LANES-1:0] lanes_kept(input logic [LANES-1:0] mine,
                                                    input logic [LANES-1:0] winner,
                                                    input logic             hit);
        return hit ? (mine & ~winner) : mine;
    endfunction

endpackage

// File: rtl/dpr_port_reg.sv
`timescale 1ns/1ps
module dpr_port_reg
    import dpr_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_lo,
    input  logic             en_hi,
    input  logic             wr,
    input  logic             oe,
    input  logic [LANES-1:0] lanes,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output port_ctl_t        ctl_q,
    output logic [AW-1:0]    addr_q,
    output logic [DW-1:0]    wdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            ctl_q.sel  <= port_selected(en_lo, en_hi);
            ctl_q.wr   <= wr;
            ctl_q.oe   <= oe;
            ctl_q.lane <= lanes;
            addr_q     <= addr;
            wdata_q    <= wdata;
        end
    end

endmodule

// File: rtl/dpr_bank.sv
`timescale 1ns/1ps
module dpr_bank
    import dpr_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 18
) (
    input  logic             clk,
    input  logic [LANES-1:0] wr_lane,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_word,
    input  logic [AW-1:0]    rd_addr0,
    input  logic [AW-1:0]    rd_addr1,
    output logic [DW-1:0]    rd_word0,
    output logic [DW-1:0]    rd_word1
);

    localparam int DEPTH = 1 << AW;
    localparam int LW    = DW / LANES;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (wr_lane[l]) begin
                store[wr_addr][l*LW +: LW] <= wr_word[l*LW +: LW];
            end
        end
    end

    assign rd_word0 = store[rd_addr0];
    assign rd_word1 = store[rd_addr1];

endmodule

// File: rtl/dpr_read_stage.sv
`timescale 1ns/1ps
module dpr_read_stage
    import dpr_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  rd_mode_e      mode,
    input  logic          req,
    input  logic [DW-1:0] word_in,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);

    logic          pipe_v;
    logic [DW-1:0] pipe_d;
    logic          sel_v;
    logic [DW-1:0] sel_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_v <= 1'b0;
            pipe_d <= '0;
        end else begin
            pipe_v <= req;
            pipe_d <= req ? word_in : '0;
        end
    end

    always_comb begin
        if (mode == RD_PIPE) begin
            sel_v = pipe_v;
            sel_d = pipe_d;
        end else begin
            sel_v = req;
            sel_d = word_in;
        end
        rvalid = sel_v;
        rdata  = sel_v ? sel_d : '0;
    end

endmodule

// File: rtl/dpram_dual_mode.sv
`timescale 1ns/1ps
module dpram_dual_mode
    import dpr_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 18
) (
    input  logic             clk_a,
    input  logic             rst_a,
    input  logic             pipe_a,
    input  logic             en_lo_a,
    input  logic             en_hi_a,
    input  logic             wr_a,
    input  logic [LANES-1:0] lanes_a,
    input  logic             oe_a,
    input  logic [AW-1:0]    addr_a,
    input  logic [DW-1:0]    wdata_a,
    output logic [DW-1:0]    rdata_a,
    output logic             rvalid_a,
    input  logic             clk_b,
    input  logic             rst_b,
    input  logic             pipe_b,
    input  logic             en_lo_b,
    input  logic             en_hi_b,
    input  logic             wr_b,
    input  logic [LANES-1:0] lanes_b,
    input  logic             oe_b,
    input  logic [AW-1:0]    addr_b,
    input  logic [DW-1:0]    wdata_b,
    output logic [DW-1:0]    rdata_b,
    output logic             rvalid_b,
    output logic             clash
);

    port_ctl_t     ctl_a, ctl_b;
    logic [AW-1:0] aq_a, aq_b;
    logic [DW-1:0] dq_a, dq_b;

    dpr_port_reg #(.AW(AW), .DW(DW)) u_reg_a (
        .clk(clk_a), .rst(rst_a), .en_lo(en_lo_a), .en_hi(en_hi_a), .wr(wr_a),
        .oe(oe_a), .lanes(lanes_a), .addr(addr_a), .wdata(wdata_a),
        .ctl_q(ctl_a), .addr_q(aq_a), .wdata_q(dq_a)
    );

    dpr_port_reg #(.AW(AW), .DW(DW)) u_reg_b (
        .clk(clk_b), .rst(rst_b), .en_lo(en_lo_b), .en_hi(en_hi_b), .wr(wr_b),
        .oe(oe_b), .lanes(lanes_b), .addr(addr_b), .wdata(wdata_b),
        .ctl_q(ctl_b), .addr_q(aq_b), .wdata_q(dq_b)
    );

    logic             wen_a, wen_b, hit;
    logic [LANES-1:0] commit_a, commit_b;
    logic [DW-1:0]    bank_a_at_a, bank_a_at_b, bank_b_at_a, bank_b_at_b;
    logic [DW-1:0]    word_at_a, word_at_b;

    assign wen_a = ctl_a.sel && ctl_a.wr;
    assign wen_b = ctl_b.sel && ctl_b.wr;
    assign hit   = wen_a && wen_b && (aq_a == aq_b);

    assign commit_a = wen_a ? ctl_a.lane : '0;
    assign commit_b = wen_b ? lanes_kept(ctl_b.lane, ctl_a.lane, hit) : '0;

    // each bank holds word XOR the other bank, so each has a single writer
    dpr_bank #(.AW(AW), .DW(DW)) u_bank_a (
        .clk(clk_a), .wr_lane(commit_a), .wr_addr(aq_a),
        .wr_word(dq_a ^ bank_b_at_a),
        .rd_addr0(aq_a), .rd_addr1(aq_b),
        .rd_word0(bank_a_at_a), .rd_word1(bank_a_at_b)
    );

    dpr_bank #(.AW(AW), .DW(DW)) u_bank_b (
        .clk(clk_b), .wr_lane(commit_b), .wr_addr(aq_b),
        .wr_word(dq_b ^ bank_a_at_b),
        .rd_addr0(aq_a), .rd_addr1(aq_b),
        .rd_word0(bank_b_at_a), .rd_word1(bank_b_at_b)
    );

    assign word_at_a = bank_a_at_a ^ bank_b_at_a;
    assign word_at_b = bank_a_at_b ^ bank_b_at_b;

    dpr_read_stage #(.DW(DW)) u_rd_a (
        .clk(clk_a), .rst(rst_a), .mode(rd_mode_e'(pipe_a)),
        .req(ctl_a.sel && !ctl_a.wr && ctl_a.oe), .word_in(word_at_a),
        .rdata(rdata_a), .rvalid(rvalid_a)
    );

    dpr_read_stage #(.DW(DW)) u_rd_b (
        .clk(clk_b), .rst(rst_b), .mode(rd_mode_e'(pipe_b)),
        .req(ctl_b.sel && !ctl_b.wr && ctl_b.oe), .word_in(word_at_b),
        .rdata(rdata_b), .rvalid(rvalid_b)
    );

    assign clash = hit;

endmodule

// File: rtl/dpr_checker.sv
`timescale 1ns/1ps
module dpr_checker #(
    parameter int AW = 10,
    parameter int DW = 18
) (
    input logic          clk_a,
    input logic          rst_a,
    input logic          rst_b,
    input logic          pipe_a,
    input logic          en_lo_a,
    input logic          en_hi_a,
    input logic          wr_a,
    input logic          oe_a,
    input logic [AW-1:0] addr_a,
    input logic [DW-1:0] rdata_a,
    input logic          rvalid_a,
    input logic          en_lo_b,
    input logic          en_hi_b,
    input logic          wr_b,
    input logic [AW-1:0] addr_b,
    input logic [DW-1:0] rdata_b,
    input logic          rvalid_b,
    input logic          clash
);

    logic rd_ok_a;
    assign rd_ok_a = !en_lo_a && en_hi_a && !wr_a && oe_a;

    assert_quiet_a_R9: assert property (@(posedge clk_a) disable iff (rst_a)
        !rvalid_a |-> rdata_a == '0);

    assert_quiet_b_R9: assert property (@(posedge clk_a) disable iff (rst_b)
        !rvalid_b |-> rdata_b == '0);

    assert_flow_source_R3: assert property (@(posedge clk_a) disable iff (rst_a || rst_b)
        (!pipe_a && !$past(pipe_a) && rvalid_a) |-> $past(rd_ok_a));

    assert_pipe_source_R4: assert property (@(posedge clk_a) disable iff (rst_a || rst_b)
        (pipe_a && $past(pipe_a) && $past(pipe_a, 2) && rvalid_a) |-> $past(rd_ok_a, 2));

    assert_pipe_reselect_R6: assert property (@(posedge clk_a) disable iff (rst_a || rst_b)
        (pipe_a && $past(pipe_a) && $past(pipe_a, 2) && $past(en_lo_a || !en_hi_a, 2))
        |-> !rvalid_a);

    assert_clash_cause_R7: assert property (@(posedge clk_a) disable iff (rst_a || rst_b)
        clash |-> $past(wr_a && wr_b && !en_lo_a && en_hi_a && !en_lo_b && en_hi_b
                        && addr_a == addr_b));

    assert_reset_quiet_R11: assert property (@(posedge clk_a)
        rst_a |=> !rvalid_a || !pipe_a);

endmodule

bind dpram_dual_mode dpr_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk_a(clk_a), .rst_a(rst_a), .rst_b(rst_b), .pipe_a(pipe_a),
    .en_lo_a(en_lo_a), .en_hi_a(en_hi_a), .wr_a(wr_a), .oe_a(oe_a),
    .addr_a(addr_a), .rdata_a(rdata_a), .rvalid_a(rvalid_a),
    .en_lo_b(en_lo_b), .en_hi_b(en_hi_b), .wr_b(wr_b), .addr_b(addr_b),
    .rdata_b(rdata_b), .rvalid_b(rvalid_b), .clash(clash)
);

// File: tb/dpram_dual_mode_test.sv
`timescale 1ns/1ps
module dpram_dual_mode_test;

    localparam int AW = 10;
    localparam int DW = 18;
    localparam int LW = DW / 2;
    localparam int LO_MASK = (1 << LW) - 1;
    localparam int HI_MASK = LO_MASK << LW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst;
    logic          pipe_a, en_lo_a, en_hi_a, wr_a, oe_a;
    logic [1:0]    lanes_a;
    logic [AW-1:0] addr_a;
    logic [DW-1:0] wdata_a, rdata_a;
    logic          rvalid_a;
    logic          pipe_b, en_lo_b, en_hi_b, wr_b, oe_b;
    logic [1:0]    lanes_b;
    logic [AW-1:0] addr_b;
    logic [DW-1:0] wdata_b, rdata_b;
    logic          rvalid_b;
    logic          clash;

    dpram_dual_mode #(.AW(AW), .DW(DW)) uut (
        .clk_a(clk), .rst_a(rst), .pipe_a(pipe_a), .en_lo_a(en_lo_a), .en_hi_a(en_hi_a),
        .wr_a(wr_a), .lanes_a(lanes_a), .oe_a(oe_a), .addr_a(addr_a), .wdata_a(wdata_a),
        .rdata_a(rdata_a), .rvalid_a(rvalid_a),
        .clk_b(clk), .rst_b(rst), .pipe_b(pipe_b), .en_lo_b(en_lo_b), .en_hi_b(en_hi_b),
        .wr_b(wr_b), .lanes_b(lanes_b), .oe_b(oe_b), .addr_b(addr_b), .wdata_b(wdata_b),
        .rdata_b(rdata_b), .rvalid_b(rvalid_b), .clash(clash)
    );

    typedef struct {
        bit       en_lo;
        bit       en_hi;
        bit       wr;
        bit       oe;
        bit [1:0] lane;
        int       addr;
        int       data;
    } op_t;

    typedef struct {
        int    due;
        int    port;
        bit    v;
        int    d;
        string tag;
    } item_t;

    item_t sb[$];
    int    model[int];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic op_t mk(bit lo, bit hi, bit w, bit o, bit [1:0] l, int a, int d);
        op_t r;
        r.en_lo = lo; r.en_hi = hi; r.wr = w; r.oe = o; r.lane = l; r.addr = a; r.data = d;
        return r;
    endfunction
    function automatic op_t rd(int a);                     return mk(0, 1, 0, 1, 2'b00, a, 0); endfunction
    function automatic op_t wrt(int a, int d, bit [1:0] l); return mk(0, 1, 1, 1, l, a, d);     endfunction
    function automatic op_t idle();                         return mk(1, 0, 0, 1, 2'b00, 0, 0); endfunction

    function automatic int mem_rd(int a);
        return model.exists(a) ? model[a] : 0;
    endfunction

    function automatic bit sel_of(op_t o);
        return !o.en_lo && o.en_hi;
    endfunction

    task automatic push(int port, int due, bit v, int d, string tag);
        item_t it;
        it.port = port; it.due = due; it.v = v; it.d = d; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic expect_port(int port, op_t o, bit pm, int e, string tag);
        int due;
        due = pm ? e + 1 : e;
        if (sel_of(o) && !o.wr && o.oe) push(port, due, 1'b1, mem_rd(o.addr), tag);
        else                            push(port, due, 1'b0, 0, tag);
    endtask

    task automatic apply_write(int a, int d, bit [1:0] l);
        int v;
        v = mem_rd(a);
        if (l[0]) v = (v & ~LO_MASK) | (d & LO_MASK);
        if (l[1]) v = (v & ~HI_MASK) | (d & HI_MASK);
        model[a] = v;
    endtask

    task automatic drive(op_t a, op_t b);
        en_lo_a = a.en_lo; en_hi_a = a.en_hi; wr_a = a.wr; oe_a = a.oe; lanes_a = a.lane;
        addr_a = a.addr[AW-1:0]; wdata_a = a.data[DW-1:0];
        en_lo_b = b.en_lo; en_hi_b = b.en_hi; wr_b = b.wr; oe_b = b.oe; lanes_b = b.lane;
        addr_b = b.addr[AW-1:0]; wdata_b = b.data[DW-1:0];
    endtask

    // driver: one capture edge for both ports, expectations go to the scoreboard
    task automatic step(op_t a, op_t b, string tag);
        int e;
        bit wa, wb, hit;
        @(negedge clk);
        drive(a, b);
        e = cyc + 1;
        expect_port(0, a, pipe_a, e, tag);
        expect_port(1, b, pipe_b, e, tag);
        wa  = sel_of(a) && a.wr;
        wb  = sel_of(b) && b.wr;
        hit = wa && wb && (a.addr == b.addr);
        push(2, e, hit, 0, tag);
        if (wb) apply_write(b.addr, b.data, hit ? (b.lane & ~a.lane) : b.lane);
        if (wa) apply_write(a.addr, a.data, a.lane);
    endtask

    task automatic set_mode(bit ma, bit mb);
        @(negedge clk);
        drive(idle(), idle());
        repeat (2) @(negedge clk);
        pipe_a = ma;
        pipe_b = mb;
    endtask

    task automatic judge(item_t it);
        bit v;
        int d;
        case (it.port)
            0:       begin v = rvalid_a; d = int'(rdata_a); end
            1:       begin v = rvalid_b; d = int'(rdata_b); end
            default: begin v = clash;    d = 0;             end
        endcase
        checks++;
        if (v !== it.v || d != it.d) begin
            errors++;
            $display("FAIL %s port %0d cycle %0d: got valid=%0b data=%h, expected valid=%0b data=%h",
                     it.tag, it.port, cyc, v, d, it.v, it.d);
        end
    endtask

    // monitor: compares every scoreboard item in its due cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                judge(sb[i]);
                sb.delete(i);
            end
        end
    end

    task automatic direct(bit ok, string tag, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h, expected %h", tag, got, exp);
        end
    endtask

    initial begin
        rst = 1'b1;
        pipe_a = 1'b0;
        pipe_b = 1'b0;
        drive(idle(), idle());
        repeat (3) @(negedge clk);
        direct(rvalid_a == 1'b0 && rvalid_b == 1'b0, "R11 rvalid in reset", rvalid_a, 0);
        direct(rdata_a == '0 && rdata_b == '0, "R11 rdata in reset", int'(rdata_a | rdata_b), 0);
        direct(clash == 1'b0, "R11 clash in reset", clash, 0);
        rst = 1'b0;
        @(negedge clk);
        direct(rvalid_a == 1'b0 && rdata_a == '0, "R11 after reset", int'(rdata_a), 0);

        // flow-through on both ports
        step(wrt(5, 'h12345, 2'b11), wrt(9, 'h0abcd, 2'b11), "R1 write both");
        step(rd(9), rd(5), "R1 R2 cross read");
        step(rd(5), rd(9), "R3 flow read");
        step(wrt(5, 'h2aaaa, 2'b11), rd(5), "R2 read beside write");
        step(rd(5), rd(5), "R2 new value");
        step(mk(1, 1, 1, 1, 2'b11, 5, 'h00001), mk(0, 0, 1, 1, 2'b11, 9, 'h00002), "R5 deselected write");
        step(rd(5), rd(9), "R5 contents kept");
        step(mk(1, 1, 0, 1, 2'b00, 5, 0), mk(0, 0, 0, 1, 2'b00, 9, 0), "R5 deselected read");
        step(wrt(20, 'h3ffff, 2'b11), wrt(21, 'h3ffff, 2'b11), "R8 prefill");
        step(wrt(20, 'h00000, 2'b10), wrt(21, 'h00000, 2'b01), "R8 single lane");
        step(rd(21), rd(20), "R8 lane read");
        step(mk(0, 1, 0, 0, 2'b00, 20, 0), rd(21), "R9 oe low");
        step(wrt(30, 'h11111, 2'b11), wrt(30, 'h22222, 2'b11), "R7 full clash");
        step(rd(30), rd(30), "R7 port A wins");
        step(wrt(31, 'h00000, 2'b11), idle(), "R7 prefill");
        step(wrt(31, 'h15555, 2'b10), wrt(31, 'h0aaaa, 2'b11), "R7 partial clash");
        step(rd(31), rd(31), "R7 lane merge");
        step(wrt(30, 'h01010, 2'b11), wrt(31, 'h02020, 2'b11), "R7 no clash other addr");
        step(wrt((1 << AW) - 1, 'h3c3c3, 2'b11), wrt(0, 'h03c3c, 2'b11), "R10 edge addr");
        step(rd(0), rd((1 << AW) - 1), "R10 edge read");

        // pipelined on both ports
        set_mode(1'b1, 1'b1);
        step(rd(5), rd(9), "R4 pipe read");
        step(rd(20), rd(21), "R4 pipe back to back");
        step(idle(), idle(), "R6 deselect");
        step(rd(30), rd(31), "R6 reselect read");
        step(rd(0), idle(), "R6 follow on");
        step(wrt(40, 'h0f0f0, 2'b11), rd(40), "R2 pipe read beside write");
        step(rd(40), mk(0, 1, 0, 0, 2'b00, 40, 0), "R9 pipe oe low");

        // mixed latency per port
        set_mode(1'b1, 1'b0);
        step(rd(40), rd(40), "R1 mixed modes");
        step(wrt(41, 'h12121, 2'b11), rd(5), "R1 mixed write");
        step(idle(), rd(41), "R1 mixed read back");
        step(rd(41), idle(), "R4 mixed pipe");

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: got %0d pending, expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule